// File: doc/BRIEF.md
# System Clock Source Selection Controller

This block owns the settings that decide where the system clock comes from. It keeps an enable bit for each of three oscillators: an internal high-speed RC, an external high-speed crystal and a slow 32 kHz-class oscillator. It also keeps two select bits. One select bit picks which high-speed oscillator forms the high-speed clock. The other picks whether the system clock is taken from that high-speed clock or from the slow oscillator. Software changes these settings through a small register port.

Every write to the source register is checked against the switching rules before it is stored. A write is refused as a whole when it would do any of the following:

- switch off the oscillator that is feeding the system clock;
- change the high-speed choice while the peripheral clocks are not fully enabled;
- point a select at an oscillator that would be off.

A refused write leaves the register as it was and raises a sticky error flag.

The select bits that software stores are not sent straight to the clock multiplexers. Each mux select is held in a register that only moves to its new value once the chosen oscillator reports ready. Until then the old select stays in force. The block also produces the core-clock and system-clock run signals for halt and sleep. These two modes never touch the stored settings.

Top module: `clk_src_ctl`

## Requirements
- R1: After reset the enables read 0b001 (RC on, crystal and slow oscillator off) and both selects read 0. The peripheral enable field reads 0x3, the error flag is 0, both mux selects are 0, and both run outputs are 1.
- R2: A source-register write whose enable bits clear the oscillator that currently feeds the system clock is refused. That oscillator is the slow one (bit 2) when the system select is 1. Otherwise it is the RC (bit 0) or the crystal (bit 1), chosen by the current high-speed select.
- R3: A source-register write that changes the high-speed select (bit 3) while the peripheral enable field is not 0x3 is refused.
- R4: A source-register write is refused when its own high-speed select names an oscillator whose enable bit in the same write is 0. It is also refused when its system select (bit 4) is 1 while its slow-oscillator enable is 0.
- R5: Any other write to address 0 is stored, and it reads back one cycle later in this layout: bits 2:0 enables (RC, crystal, slow), bit 3 high-speed select, bit 4 system select. The enable outputs follow the stored bits.
- R6: The high-speed mux select takes the stored high-speed select on the edge after that oscillator's ready input (bit 0 RC, bit 1 crystal) is 1. Otherwise it holds its value.
- R7: The system mux select takes the stored system select on an edge where the target is ready, and otherwise holds. For the slow target, ready means slow-oscillator ready (bit 2). For the high-speed target, ready means the high-speed mux select already matches its stored select and that oscillator is ready.
- R8: The error flag is bit 0 of address 2, with the high-speed mux select at bit 1 and the system mux select at bit 2. Any refused write sets the flag. It stays set through later accepted writes, and it clears only on a write to address 2 with bit 0 set.
- R9: The core-clock run output is 0 while halt or sleep is requested. The system-clock run output is 0 while sleep is requested. Entering or leaving either mode leaves all stored settings and enables unchanged.
- R10: A write to address 1 always stores its low two bits as the peripheral enable field, which drives the peripheral gate output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address (0 source, 1 peripheral enable, 2 status) |
| wrData | input | 5 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 5 | Read data, combinational from rdAddr |
| oscRdy | input | 3 | Ready per oscillator (0 RC, 1 crystal, 2 slow) |
| haltIn | input | 1 | Halt request |
| sleepIn | input | 1 | Sleep request |
| oscEn | output | 3 | Oscillator enables |
| hsMuxSel | output | 1 | High-speed mux select (0 RC, 1 crystal) |
| sysMuxSel | output | 1 | System mux select (0 high-speed, 1 slow) |
| pclkGate | output | 2 | Peripheral clock enable field |
| coreClkOn | output | 1 | Core clock run enable |
| sysClkOn | output | 1 | System clock run enable |

## Verification
The results arrive at different times:

- A write strobe sampled on an edge is visible in the register readback, the enable outputs and the error flag right after that edge.
- The mux selects follow on the next edge, and only if the ready input is high there.
- The run outputs follow halt and sleep combinationally.

The driver pushes each expected value when the stimulus for it is in place. The monitor checks each item a quarter period after the following rising edge. A write therefore finishes one edge before its check, which is exactly the one extra edge the mux selects need. When a ready input is dropped first, the check shows that the select holds.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

  localparam int NUM_OSC = 3;
  localparam int OSC_RC = 0;
  localparam int OSC_XT = 1;
  localparam int OSC_LO = 2;
  localparam int CFG_HS_BIT = NUM_OSC;
  localparam int CFG_SYS_BIT = NUM_OSC + 1;
  localparam int CFG_W = NUM_OSC + 2;

  localparam int ADR_CFG = 0;
  localparam int ADR_GATE = 1;
  localparam int ADR_STAT = 2;

  typedef struct packed {
    logic sysSel;
    logic hsSel;
    logic [NUM_OSC-1:0] en;
  } srcCfg_t;

  typedef struct packed {
    logic cfgLoad;
    logic gateLoad;
    logic errSet;
    logic errClr;
  } ctrlStrobe_t;

  function automatic srcCfg_t cfgFromBits(input logic [CFG_W-1:0] b);
    srcCfg_t c;
    c.en = b[NUM_OSC-1:0];
    c.hsSel = b[CFG_HS_BIT];
    c.sysSel = b[CFG_SYS_BIT];
    return c;
  endfunction

endpackage

// File: rtl/clk_src_rules.sv
module clk_src_rules
  import clk_src_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int GATE_W = 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CFG_W-1:0]  wrData,
  input  logic              curHsSel,
  input  logic              curSysSel,
  input  logic [GATE_W-1:0] gateVal,
  output ctrlStrobe_t       strobe
);

  localparam logic [GATE_W-1:0] GATE_ALL = '1;

  srcCfg_t newCfg;
  logic curActiveKept;
  logic hsLocked;
  logic newHsOn;
  logic newSysOn;
  logic legal;
  logic isCfg;

  always_comb begin
    newCfg = cfgFromBits(wrData);
    // the oscillator feeding the system clock right now must stay enabled
    if (curSysSel) curActiveKept = newCfg.en[OSC_LO];
    else curActiveKept = curHsSel ? newCfg.en[OSC_XT] : newCfg.en[OSC_RC];
    hsLocked = (newCfg.hsSel != curHsSel) && (gateVal != GATE_ALL);
    newHsOn = newCfg.hsSel ? newCfg.en[OSC_XT] : newCfg.en[OSC_RC];
    newSysOn = !newCfg.sysSel || newCfg.en[OSC_LO];
    legal = curActiveKept && !hsLocked && newHsOn && newSysOn;
    isCfg = wrEn && (wrAddr == ADDR_W'(ADR_CFG));
    strobe.cfgLoad = isCfg && legal;
    strobe.errSet = isCfg && !legal;
    strobe.gateLoad = wrEn && (wrAddr == ADDR_W'(ADR_GATE));
    strobe.errClr = wrEn && (wrAddr == ADDR_W'(ADR_STAT)) && wrData[0];
  end

endmodule

// File: rtl/clk_src_regs.sv
module clk_src_regs
  import clk_src_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int GATE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [CFG_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic [NUM_OSC-1:0] oscRdy,
  input  logic               haltIn,
  input  logic               sleepIn,
  output srcCfg_t            cfgQ,
  output logic [GATE_W-1:0]  gateQ,
  output logic               errQ,
  output logic               hsMuxQ,
  output logic               sysMuxQ,
  output logic [CFG_W-1:0]   rdData,
  output logic               coreClkOn,
  output logic               sysClkOn
);

  localparam srcCfg_t CFG_RESET = '{sysSel: 1'b0, hsSel: 1'b0,
                                    en: NUM_OSC'(1 << OSC_RC)};

  logic hsMuxD;
  logic sysMuxD;
  logic sysTgtRdy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= CFG_RESET;
      gateQ <= '1;
      errQ <= 1'b0;
    end else begin
      if (strobe.cfgLoad) cfgQ <= cfgFromBits(wrData);
      if (strobe.gateLoad) gateQ <= wrData[GATE_W-1:0];
      if (strobe.errSet) errQ <= 1'b1;
      else if (strobe.errClr) errQ <= 1'b0;
    end
  end

  always_comb begin
    hsMuxD = hsMuxQ;
    if (cfgQ.hsSel ? oscRdy[OSC_XT] : oscRdy[OSC_RC]) hsMuxD = cfgQ.hsSel;
    if (cfgQ.sysSel) sysTgtRdy = oscRdy[OSC_LO];
    else sysTgtRdy = (hsMuxQ == cfgQ.hsSel) &&
                     (hsMuxQ ? oscRdy[OSC_XT] : oscRdy[OSC_RC]);
    sysMuxD = sysTgtRdy ? cfgQ.sysSel : sysMuxQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsMuxQ <= 1'b0;
      sysMuxQ <= 1'b0;
    end else begin
      hsMuxQ <= hsMuxD;
      sysMuxQ <= sysMuxD;
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_W'(ADR_CFG):  rdData = cfgQ;
      ADDR_W'(ADR_GATE): rdData = CFG_W'(gateQ);
      ADDR_W'(ADR_STAT): rdData = CFG_W'({sysMuxQ, hsMuxQ, errQ});
      default:           rdData = '0;
    endcase
  end

  assign coreClkOn = !(haltIn || sleepIn);
  assign sysClkOn = !sleepIn;

endmodule

// File: rtl/clk_src_ctl.sv
module clk_src_ctl
  import clk_src_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int GATE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [CFG_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [CFG_W-1:0]   rdData,
  input  logic [NUM_OSC-1:0] oscRdy,
  input  logic               haltIn,
  input  logic               sleepIn,
  output logic [NUM_OSC-1:0] oscEn,
  output logic               hsMuxSel,
  output logic               sysMuxSel,
  output logic [GATE_W-1:0]  pclkGate,
  output logic               coreClkOn,
  output logic               sysClkOn
);

  ctrlStrobe_t strobe;
  srcCfg_t cfgQ;
  logic errFlag;
  logic cfgHsSel;
  logic cfgSysSel;

  assign cfgHsSel = cfgQ.hsSel;
  assign cfgSysSel = cfgQ.sysSel;
  assign oscEn = cfgQ.en;

  clk_src_rules #(.ADDR_W(ADDR_W), .GATE_W(GATE_W)) u_rules (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .curHsSel(cfgHsSel), .curSysSel(cfgSysSel),
    .gateVal(pclkGate), .strobe(strobe)
  );

  clk_src_regs #(.ADDR_W(ADDR_W), .GATE_W(GATE_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdAddr(rdAddr), .oscRdy(oscRdy), .haltIn(haltIn), .sleepIn(sleepIn),
    .cfgQ(cfgQ), .gateQ(pclkGate), .errQ(errFlag), .hsMuxQ(hsMuxSel),
    .sysMuxQ(sysMuxSel), .rdData(rdData), .coreClkOn(coreClkOn),
    .sysClkOn(sysClkOn)
  );

endmodule

// File: rtl/clk_src_ctl_chk.sv
module clk_src_ctl_chk
  import clk_src_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int GATE_W = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic               wrHsBit,
  input logic               wrClrBit,
  input logic               xtRdy,
  input logic               loRdy,
  input logic               sleepIn,
  input logic [NUM_OSC-1:0] oscEn,
  input logic               hsMuxSel,
  input logic               sysMuxSel,
  input logic [GATE_W-1:0]  pclkGate,
  input logic               cfgHsSel,
  input logic               cfgSysSel,
  input logic               errFlag
);

  localparam logic [GATE_W-1:0] GATE_ALL = '1;

  a_r2_active_src_on: assert property (@(posedge clk) disable iff (!rstN)
    cfgSysSel ? oscEn[OSC_LO] : (cfgHsSel ? oscEn[OSC_XT] : oscEn[OSC_RC]));

  a_r4_hs_choice_on: assert property (@(posedge clk) disable iff (!rstN)
    cfgHsSel ? oscEn[OSC_XT] : oscEn[OSC_RC]);

  a_r3_hs_locked: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(ADR_CFG) && pclkGate != GATE_ALL &&
     wrHsBit != cfgHsSel) |=> $stable(cfgHsSel));

  a_r6_xt_wait_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsMuxSel) |-> $past(xtRdy));

  a_r7_lo_wait_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysMuxSel) |-> $past(loRdy));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !(wrEn && wrAddr == ADDR_W'(ADR_STAT) && wrClrBit)) |=> errFlag);

  a_r9_sleep_hold: assert property (@(posedge clk) disable iff (!rstN)
    (sleepIn && !wrEn) |=> ($stable(oscEn) && $stable(cfgHsSel) && $stable(cfgSysSel)));

endmodule

bind clk_src_ctl clk_src_ctl_chk #(.ADDR_W(ADDR_W), .GATE_W(GATE_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrHsBit(wrData[clk_src_pkg::CFG_HS_BIT]), .wrClrBit(wrData[0]),
  .xtRdy(oscRdy[clk_src_pkg::OSC_XT]), .loRdy(oscRdy[clk_src_pkg::OSC_LO]),
  .sleepIn(sleepIn), .oscEn(oscEn), .hsMuxSel(hsMuxSel),
  .sysMuxSel(sysMuxSel), .pclkGate(pclkGate), .cfgHsSel(cfgHsSel),
  .cfgSysSel(cfgSysSel), .errFlag(errFlag)
);

// File: tb/clk_src_ctl_bench.sv
module clk_src_ctl_bench;

  localparam int PERIOD = 10;
  localparam int K_RD = 0, K_EN = 1, K_HS = 2, K_SYS = 3, K_GATE = 4, K_CORE = 5, K_SCLK = 6;

  typedef struct {
    int kind;
    logic [1:0] addr;
    logic [4:0] exp;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [4:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [4:0] rdData;
  logic [2:0] oscRdy = 3'b111;
  logic haltIn = 1'b0;
  logic sleepIn = 1'b0;
  logic [2:0] oscEn;
  logic hsMuxSel, sysMuxSel;
  logic [1:0] pclkGate;
  logic coreClkOn, sysClkOn;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  clk_src_ctl u_clk_src_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .oscRdy(oscRdy), .haltIn(haltIn),
    .sleepIn(sleepIn), .oscEn(oscEn), .hsMuxSel(hsMuxSel),
    .sysMuxSel(sysMuxSel), .pclkGate(pclkGate), .coreClkOn(coreClkOn),
    .sysClkOn(sysClkOn)
  );

  always #(PERIOD / 2) clk = ~clk;

  function automatic logic [4:0] observe(input int kind);
    case (kind)
      K_RD:    return rdData;
      K_EN:    return 5'(oscEn);
      K_HS:    return 5'(hsMuxSel);
      K_SYS:   return 5'(sysMuxSel);
      K_GATE:  return 5'(pclkGate);
      K_CORE:  return 5'(coreClkOn);
      default: return 5'(sysClkOn);
    endcase
  endfunction

  // monitor: one item per cycle, checked a quarter period after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD / 4);
      if (q.size() > 0) begin
        item_t it;
        logic [4:0] got;
        it = q.pop_front();
        if (it.kind == K_RD) rdAddr = it.addr;
        #1;
        got = observe(it.kind);
        checks++;
        if (got !== it.exp) begin
          fails++;
          $display("FAIL %s: got 0x%0h expected 0x%0h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic expect_item(input int kind, input logic [1:0] addr,
                             input logic [4:0] exp, input string tag);
    item_t it;
    it.kind = kind;
    it.addr = addr;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] addr, input logic [4:0] data);
    wrEn = 1'b1;
    wrAddr = addr;
    wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_item(K_RD, 2'd0, 5'h01, "R1 source reg");
    expect_item(K_RD, 2'd1, 5'h03, "R1 gate field");
    expect_item(K_RD, 2'd2, 5'h00, "R1 status");
    expect_item(K_EN, 2'd0, 5'h01, "R1 enables");
    expect_item(K_HS, 2'd0, 5'h00, "R1 hs mux");
    expect_item(K_SYS, 2'd0, 5'h00, "R1 sys mux");
    expect_item(K_CORE, 2'd0, 5'h01, "R1 core run");
    expect_item(K_SCLK, 2'd0, 5'h01, "R1 sys run");
    // R2 try to turn off the running RC
    wr(2'd0, 5'h00);
    expect_item(K_RD, 2'd0, 5'h01, "R2 RC kept");
    expect_item(K_RD, 2'd2, 5'h01, "R2 err set");
    wr(2'd2, 5'h01);
    expect_item(K_RD, 2'd2, 5'h00, "R8 err cleared");
    // R5 enable crystal
    wr(2'd0, 5'h03);
    expect_item(K_RD, 2'd0, 5'h03, "R5 crystal on");
    expect_item(K_EN, 2'd0, 5'h03, "R5 enables out");
    // R6 switch to crystal while not ready
    oscRdy = 3'b101;
    wr(2'd0, 5'h0B);
    expect_item(K_RD, 2'd0, 5'h0B, "R5 hs select stored");
    expect_item(K_HS, 2'd0, 5'h00, "R6 hs mux holds");
    oscRdy = 3'b111;
    expect_item(K_HS, 2'd0, 5'h01, "R6 hs mux moves");
    // R5 RC off is fine while crystal feeds
    wr(2'd0, 5'h0A);
    expect_item(K_RD, 2'd0, 5'h0A, "R5 RC off accepted");
    wr(2'd0, 5'h08);
    expect_item(K_RD, 2'd0, 5'h0A, "R2 crystal kept");
    expect_item(K_RD, 2'd2, 5'h03, "R2 err with hs mux");
    wr(2'd2, 5'h01);
    // R10 gate field
    wr(2'd1, 5'h01);
    expect_item(K_GATE, 2'd0, 5'h01, "R10 gate out");
    expect_item(K_RD, 2'd1, 5'h01, "R10 gate read");
    wr(2'd0, 5'h0B);
    wr(2'd0, 5'h03);
    expect_item(K_RD, 2'd0, 5'h0B, "R3 hs change blocked");
    expect_item(K_RD, 2'd2, 5'h03, "R3 err set");
    wr(2'd2, 5'h01);
    wr(2'd1, 5'h03);
    wr(2'd0, 5'h03);
    expect_item(K_RD, 2'd0, 5'h03, "R3 hs change allowed");
    expect_item(K_HS, 2'd0, 5'h00, "R6 hs mux back to RC");
    // R4 selecting oscillators that are off
    wr(2'd0, 5'h13);
    expect_item(K_RD, 2'd0, 5'h03, "R4 slow off refused");
    expect_item(K_RD, 2'd2, 5'h01, "R4 err set");
    wr(2'd2, 5'h01);
    wr(2'd0, 5'h09);
    expect_item(K_RD, 2'd0, 5'h03, "R4 crystal off refused");
    wr(2'd2, 5'h01);
    // R7 switch to slow oscillator with ready late
    wr(2'd0, 5'h07);
    oscRdy = 3'b011;
    wr(2'd0, 5'h17);
    expect_item(K_RD, 2'd0, 5'h17, "R5 slow select stored");
    expect_item(K_SYS, 2'd0, 5'h00, "R7 sys mux holds");
    oscRdy = 3'b111;
    expect_item(K_SYS, 2'd0, 5'h01, "R7 sys mux moves");
    // R2 slow feeds now; R8 stickiness across an accepted write
    wr(2'd0, 5'h13);
    wr(2'd0, 5'h15);
    expect_item(K_RD, 2'd0, 5'h15, "R5 crystal off accepted");
    expect_item(K_RD, 2'd2, 5'h05, "R8 err sticky");
    wr(2'd2, 5'h00);
    expect_item(K_RD, 2'd2, 5'h05, "R8 zero write keeps err");
    wr(2'd2, 5'h01);
    expect_item(K_RD, 2'd2, 5'h04, "R8 err cleared again");
    // R9 halt and sleep
    haltIn = 1'b1;
    expect_item(K_CORE, 2'd0, 5'h00, "R9 halt stops core");
    expect_item(K_SCLK, 2'd0, 5'h01, "R9 halt keeps sys");
    sleepIn = 1'b1;
    expect_item(K_SCLK, 2'd0, 5'h00, "R9 sleep stops sys");
    expect_item(K_RD, 2'd0, 5'h15, "R9 settings in sleep");
    haltIn = 1'b0;
    sleepIn = 1'b0;
    expect_item(K_CORE, 2'd0, 5'h01, "R9 core resumes");
    expect_item(K_RD, 2'd0, 5'h15, "R9 settings after wake");
    expect_item(K_SYS, 2'd0, 5'h01, "R9 sys mux after wake");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule